// File: doc/BRIEF.md
# Time-Slotted Shared Memory Scheduler

This block lets five memory users share one 64-bit synchronous SRAM without any request arbitration. A free-running four-step rotation hands each bus cycle to one slot. The processor owns one slot and each network receive interface owns one. The two network send interfaces share the remaining slot. A select input decides which of the two senders owns it, so only one of them can feed the network at a time. In its slot the owning unit may move one 8-byte doubleword. Over a full rotation this gives each unit a guaranteed, unbuffered share of the memory bandwidth.

A unit watches the slot output and presents its valid, write, address and write data during its own slot cycle. The block registers the chosen request onto the SRAM bus on the next clock edge. The SRAM registers read data one edge after that. The block then captures that data and returns it with a valid pulse and the requester's ID. As a result, read data appears exactly three cycles after the slot in which the read was presented. A request that the unselected sender makes in the send slot is refused with an error pulse and causes no memory access.

Top module: `tdm_mem_sched`

## Requirements
- R1: While reset is asserted, and in the cycle after any reset edge, the slot output is 0 and mem_en, rd_valid and snd_err are all low.
- R2: Out of reset the slot output steps 0,1,2,3,0,... once per clock, without skipping. Slot code 0 belongs to the processor, 1 to the send slot, 2 to receive port 0 and 3 to receive port 1.
- R3: When the owning unit's valid is high during slot cycle t, then in cycle t+1 mem_en is 1 and mem_we, mem_addr and mem_wdata equal that unit's write flag, address and data. A request from a unit that does not own the slot in that cycle is ignored: mem_en stays 0 in cycle t+1.
- R4: A slot whose owner does not request leaves mem_en at 0 in the following cycle.
- R5: A read presented in cycle t returns in cycle t+3 with rd_valid=1, rd_data equal to the SRAM word, and rd_id set to the requester code. The codes are 0 processor, 1 sender 0, 2 sender 1, 3 receive 0, 4 receive 1.
- R6: A write produces no rd_valid pulse.
- R7: With snd_sel=0 sender 0 owns the send slot; with snd_sel=1 sender 1 owns it.
- R8: If the unselected sender's valid is high in a send-slot cycle, snd_err is 1 for exactly the following cycle and that request reaches no memory access. The selected sender's request in the same slot still proceeds.
- R9: Accesses complete in slot order. A read in a later slot returns the most recently written value, including a read in the slot right after the write. Of two writes to one address, the later one wins.
- R10: A reset that arrives while a read is in flight cancels it: no rd_valid follows, and the rotation restarts from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 5 | Per-requester request valid, indexed by requester code |
| req_write_i | input | 5 | Per-requester write flag (1 = write) |
| req_addr_i | input | 5x30 | Per-requester doubleword address |
| req_wdata_i | input | 5x64 | Per-requester write data |
| snd_sel_i | input | 1 | Chooses which sender owns the send slot |
| slot_o | output | 2 | Current slot code |
| mem_en_o | output | 1 | SRAM access enable |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | 30 | SRAM address |
| mem_wdata_o | output | 64 | SRAM write data |
| mem_rdata_i | input | 64 | SRAM read data, one cycle after the address |
| rd_valid_o | output | 1 | Read data return strobe |
| rd_id_o | output | 3 | Requester code of the returned data |
| rd_data_o | output | 64 | Returned read data |
| snd_err_o | output | 1 | Refused-sender error pulse |

## Verification
The bench targets the send slot, where both senders can raise valid at once. A design that muxed the wrong sender would put the refused sender's address on the bus, and one that dropped the refusal would never pulse the error. It issues a write and then a read to the same address in back-to-back slots. It also writes one address from two slots in a row. Forwarding or ordering bugs would then return stale data. It raises a reset one cycle after a read issues, which catches a tag pipeline that survives reset and emits a phantom return. It also counts the return latency to the exact cycle and drives a non-owner's valid in a foreign slot, which catches an off-by-one pipeline or a mux that ignores slot ownership.

// File: rtl/tdm_mem_pkg.sv
package tdm_mem_pkg;
    localparam int NREQ   = 5;
    localparam int NSLOT  = 4;
    localparam int SLOTW  = $clog2(NSLOT);
    localparam int IDW    = $clog2(NREQ);
    localparam int DEF_AW = 30;
    localparam int DEF_DW = 64;

    typedef enum logic [SLOTW-1:0] {
        SLOT_CPU   = 2'd0,
        SLOT_SEND  = 2'd1,
        SLOT_RECV0 = 2'd2,
        SLOT_RECV1 = 2'd3
    } slot_e;

    localparam logic [IDW-1:0] ID_CPU   = 3'd0;
    localparam logic [IDW-1:0] ID_SEND0 = 3'd1;
    localparam logic [IDW-1:0] ID_SEND1 = 3'd2;
    localparam logic [IDW-1:0] ID_RECV0 = 3'd3;
    localparam logic [IDW-1:0] ID_RECV1 = 3'd4;
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr
    import tdm_mem_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    output slot_e slot_o
);
    typedef struct packed {
        slot_e slot;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == slot_e'(NSLOT - 1)) begin
            st_d.slot = SLOT_CPU;
        end else begin
            st_d.slot = slot_e'(st_q.slot + 1'b1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{slot: SLOT_CPU};
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;
endmodule

// File: rtl/tdm_req_mux.sv
module tdm_req_mux
    import tdm_mem_pkg::*;
#(
    parameter int AW = DEF_AW,
    parameter int DW = DEF_DW
) (
    input  slot_e                    slot_i,
    input  logic [NREQ-1:0]          req_valid_i,
    input  logic [NREQ-1:0]          req_write_i,
    input  logic [NREQ-1:0][AW-1:0]  req_addr_i,
    input  logic [NREQ-1:0][DW-1:0]  req_wdata_i,
    input  logic                     snd_sel_i,
    output logic                     sel_valid_o,
    output logic                     sel_write_o,
    output logic [AW-1:0]            sel_addr_o,
    output logic [DW-1:0]            sel_wdata_o,
    output logic [IDW-1:0]           sel_id_o,
    output logic                     refuse_o
);
    logic [IDW-1:0] owner;
    logic [IDW-1:0] loser;

    always_comb begin
        loser = snd_sel_i ? ID_SEND0 : ID_SEND1;
        unique case (slot_i)
            SLOT_CPU:   owner = ID_CPU;
            SLOT_SEND:  owner = snd_sel_i ? ID_SEND1 : ID_SEND0;
            SLOT_RECV0: owner = ID_RECV0;
            default:    owner = ID_RECV1;
        endcase
        sel_valid_o = req_valid_i[owner];
        sel_write_o = req_write_i[owner];
        sel_addr_o  = req_addr_i[owner];
        sel_wdata_o = req_wdata_i[owner];
        sel_id_o    = owner;
        refuse_o    = (slot_i == SLOT_SEND) && req_valid_i[loser];
    end
endmodule

// File: rtl/tdm_rd_pipe.sv
module tdm_rd_pipe
    import tdm_mem_pkg::*;
#(
    parameter int DW      = DEF_DW,
    parameter int MEM_LAT = 1
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           iss_rd_i,
    input  logic [IDW-1:0] iss_id_i,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           rd_valid_o,
    output logic [IDW-1:0] rd_id_o,
    output logic [DW-1:0]  rd_data_o
);
    typedef struct packed {
        logic           v;
        logic [IDW-1:0] id;
    } tag_t;

    typedef struct packed {
        tag_t [MEM_LAT-1:0] pipe;
        logic               out_v;
        logic [IDW-1:0]     out_id;
        logic [DW-1:0]      out_data;
    } rp_t;

    rp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = '{v: iss_rd_i, id: iss_id_i};
        for (int i = 1; i < MEM_LAT; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.out_v  = st_q.pipe[MEM_LAT-1].v;
        st_d.out_id = st_q.pipe[MEM_LAT-1].id;
        if (st_q.pipe[MEM_LAT-1].v) begin
            st_d.out_data = mem_rdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o = st_q.out_v;
    assign rd_id_o    = st_q.out_id;
    assign rd_data_o  = st_q.out_data;
endmodule

// File: rtl/tdm_mem_sched.sv
module tdm_mem_sched
    import tdm_mem_pkg::*;
#(
    parameter int AW      = DEF_AW,
    parameter int DW      = DEF_DW,
    parameter int MEM_LAT = 1
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [NREQ-1:0]         req_valid_i,
    input  logic [NREQ-1:0]         req_write_i,
    input  logic [NREQ-1:0][AW-1:0] req_addr_i,
    input  logic [NREQ-1:0][DW-1:0] req_wdata_i,
    input  logic                    snd_sel_i,
    output logic [SLOTW-1:0]        slot_o,
    output logic                    mem_en_o,
    output logic                    mem_we_o,
    output logic [AW-1:0]           mem_addr_o,
    output logic [DW-1:0]           mem_wdata_o,
    input  logic [DW-1:0]           mem_rdata_i,
    output logic                    rd_valid_o,
    output logic [IDW-1:0]          rd_id_o,
    output logic [DW-1:0]           rd_data_o,
    output logic                    snd_err_o
);
    typedef struct packed {
        logic           en;
        logic           we;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [IDW-1:0] id;
        logic           err;
    } iss_t;

    slot_e          slot;
    logic           sel_valid;
    logic           sel_write;
    logic [AW-1:0]  sel_addr;
    logic [DW-1:0]  sel_wdata;
    logic [IDW-1:0] sel_id;
    logic           refuse;
    iss_t           st_d, st_q;

    tdm_slot_ctr u_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .slot_o (slot)
    );

    tdm_req_mux #(.AW(AW), .DW(DW)) u_mux (
        .slot_i      (slot),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .snd_sel_i   (snd_sel_i),
        .sel_valid_o (sel_valid),
        .sel_write_o (sel_write),
        .sel_addr_o  (sel_addr),
        .sel_wdata_o (sel_wdata),
        .sel_id_o    (sel_id),
        .refuse_o    (refuse)
    );

    always_comb begin
        st_d       = st_q;
        st_d.en    = sel_valid;
        st_d.we    = sel_valid && sel_write;
        st_d.err   = refuse;
        if (sel_valid) begin
            st_d.addr  = sel_addr;
            st_d.wdata = sel_wdata;
            st_d.id    = sel_id;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    tdm_rd_pipe #(.DW(DW), .MEM_LAT(MEM_LAT)) u_rd (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .iss_rd_i    (st_q.en && !st_q.we),
        .iss_id_i    (st_q.id),
        .mem_rdata_i (mem_rdata_i),
        .rd_valid_o  (rd_valid_o),
        .rd_id_o     (rd_id_o),
        .rd_data_o   (rd_data_o)
    );

    assign slot_o      = slot;
    assign mem_en_o    = st_q.en;
    assign mem_we_o    = st_q.we;
    assign mem_addr_o  = st_q.addr;
    assign mem_wdata_o = st_q.wdata;
    assign snd_err_o   = st_q.err;
endmodule

// File: rtl/tdm_mem_sched_chk.sv
module tdm_mem_sched_chk
    import tdm_mem_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic [NREQ-1:0]  req_valid_i,
    input logic [SLOTW-1:0] slot_o,
    input logic             mem_en_o,
    input logic             mem_we_o,
    input logic             rd_valid_o,
    input logic             snd_err_o
);
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (slot_o == 2'd0) && !mem_en_o && !rd_valid_o && !snd_err_o);

    assert_slot_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> slot_o == 2'($past(slot_o) + 2'd1));

    assert_access_needs_req_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_en_o |-> $past(req_valid_i) != '0);

    assert_return_after_read_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_o |-> $past(mem_en_o, 2));

    assert_no_return_for_write_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_o |-> !$past(mem_we_o, 2));

    assert_err_in_send_slot_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        snd_err_o |-> $past(slot_o) == 2'd1);

    assert_err_one_cycle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        snd_err_o |=> !snd_err_o);
endmodule

bind tdm_mem_sched tdm_mem_sched_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_valid_i (req_valid_i),
    .slot_o      (slot_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .rd_valid_o  (rd_valid_o),
    .snd_err_o   (snd_err_o)
);

// File: tb/tdm_mem_sched_tb.sv
module tdm_mem_sched_tb;
    localparam int AW = 30;
    localparam int DW = 64;

    typedef struct packed {
        logic [2:0]  unit;
        logic        we;
        logic [7:0]  addr;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b1, 8'h10, 64'hA0A0_0000_0000_0001},
        '{3'd3, 1'b1, 8'h11, 64'hB1B1_0000_0000_0002},
        '{3'd4, 1'b1, 8'h12, 64'hC2C2_0000_0000_0003},
        '{3'd1, 1'b0, 8'h10, 64'h0},
        '{3'd0, 1'b0, 8'h11, 64'h0},
        '{3'd2, 1'b1, 8'h13, 64'hD3D3_0000_0000_0004},
        '{3'd4, 1'b0, 8'h13, 64'h0},
        '{3'd3, 1'b0, 8'h12, 64'h0},
        '{3'd0, 1'b1, 8'h10, 64'hE4E4_0000_0000_0005},
        '{3'd2, 1'b0, 8'h10, 64'h0},
        '{3'd3, 1'b1, 8'h21, 64'h1111_2222_3333_4444},
        '{3'd4, 1'b1, 8'h21, 64'h5555_6666_7777_8888},
        '{3'd0, 1'b0, 8'h21, 64'h0}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [4:0]           req_valid = '0;
    logic [4:0]           req_write = '0;
    logic [4:0][AW-1:0]   req_addr  = '0;
    logic [4:0][DW-1:0]   req_wdata = '0;
    logic                 snd_sel   = 1'b0;
    logic [1:0]           slot;
    logic                 mem_en, mem_we;
    logic [AW-1:0]        mem_addr;
    logic [DW-1:0]        mem_wdata;
    logic [DW-1:0]        mem_rdata;
    logic                 rd_valid;
    logic [2:0]           rd_id;
    logic [DW-1:0]        rd_data;
    logic                 snd_err;

    logic [63:0] sram    [256];
    logic [63:0] exp_mem [256];
    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) sram[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= sram[mem_addr[7:0]];
        end
    end

    tdm_mem_sched u_dut (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .snd_sel_i(snd_sel), .slot_o(slot),
        .mem_en_o(mem_en), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata),
        .rd_valid_o(rd_valid), .rd_id_o(rd_id), .rd_data_o(rd_data),
        .snd_err_o(snd_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic logic [1:0] slot_of(input logic [2:0] unit);
        case (unit)
            3'd0:       return 2'd0;
            3'd1, 3'd2: return 2'd1;
            3'd3:       return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

    task automatic wait_slot(input logic [1:0] s);
        while (slot != s) @(negedge clk);
    endtask

    task automatic put(input logic [2:0] u, input logic we, input logic [7:0] a, input logic [63:0] d);
        req_valid[u] = 1'b1;
        req_write[u] = we;
        req_addr[u]  = AW'(a);
        req_wdata[u] = d;
    endtask

    task automatic clear_reqs();
        req_valid = '0;
        req_write = '0;
    endtask

    task automatic do_access(input vec_t v);
        wait_slot(slot_of(v.unit));
        snd_sel = (v.unit == 3'd2);
        put(v.unit, v.we, v.addr, v.data);
        @(negedge clk);
        clear_reqs();
        // R3 and R7: owning unit's request reaches the bus one cycle later
        check(mem_en && mem_we == v.we && mem_addr == AW'(v.addr), "R3/R7 issue",
              {31'd0, mem_en, mem_we, mem_addr[30:0]}, {31'd0, 1'b1, v.we, 23'd0, v.addr});
        if (v.we) begin
            check(mem_wdata == v.data, "R3 wdata", mem_wdata, v.data);
            exp_mem[v.addr] = v.data;
            repeat (2) @(negedge clk);
            check(!rd_valid, "R6 no return", {63'd0, rd_valid}, 64'd0);
        end else begin
            repeat (2) @(negedge clk);
            check(rd_valid && rd_id == v.unit, "R5/R7 return id",
                  {60'd0, rd_valid, rd_id}, {60'd0, 1'b1, v.unit});
            check(rd_data == exp_mem[v.addr], "R5/R9 return data", rd_data, exp_mem[v.addr]);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [1:0] prev;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(slot == 2'd0 && !mem_en && !rd_valid && !snd_err, "R1 reset state",
              {59'd0, slot, mem_en, rd_valid, snd_err}, 64'd0);
        rst = 1'b0;

        // R2: rotation order
        prev = slot;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(slot == 2'(prev + 2'd1), "R2 slot step", {62'd0, slot}, {62'd0, 2'(prev + 2'd1)});
            prev = slot;
        end

        // R4: idle slots produce no access
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!mem_en, "R4 idle slot", {63'd0, mem_en}, 64'd0);
        end

        // Vector walk: R3, R5, R6, R7, R9
        for (int i = 0; i < NV; i++) begin
            do_access(VEC[i]);
        end

        // R3: non-owner request in a foreign slot is ignored
        wait_slot(2'd0);
        put(3'd4, 1'b1, 8'h40, 64'hDEAD);
        @(negedge clk);
        clear_reqs();
        check(!mem_en, "R3 non-owner ignored", {63'd0, mem_en}, 64'd0);

        // R8: unselected sender alone is refused
        wait_slot(2'd1);
        snd_sel = 1'b0;
        put(3'd2, 1'b0, 8'h10, 64'd0);
        @(negedge clk);
        clear_reqs();
        check(snd_err && !mem_en, "R8 refuse alone", {62'd0, snd_err, mem_en}, 64'd2);
        @(negedge clk);
        check(!snd_err, "R8 error one cycle", {63'd0, snd_err}, 64'd0);
        @(negedge clk);
        check(!rd_valid, "R8 no return for refused", {63'd0, rd_valid}, 64'd0);

        // R8: both senders, selected proceeds, other refused
        wait_slot(2'd1);
        snd_sel = 1'b0;
        put(3'd1, 1'b0, 8'h11, 64'd0);
        put(3'd2, 1'b1, 8'h30, 64'hBAD0);
        @(negedge clk);
        clear_reqs();
        check(snd_err && mem_en && !mem_we && mem_addr == AW'(8'h11), "R8 selected proceeds",
              {32'd0, snd_err, mem_en, mem_we, mem_addr[28:0]}, {32'd0, 3'b110, 29'h11});
        repeat (2) @(negedge clk);
        check(rd_valid && rd_id == 3'd1 && rd_data == exp_mem[8'h11], "R8 selected return",
              rd_data, exp_mem[8'h11]);

        // R9: write then read of same address in adjacent slots
        wait_slot(2'd0);
        put(3'd0, 1'b1, 8'h20, 64'hFEED_F00D_0000_0077);
        @(negedge clk);
        clear_reqs();
        snd_sel = 1'b0;
        put(3'd1, 1'b0, 8'h20, 64'd0);
        exp_mem[8'h20] = 64'hFEED_F00D_0000_0077;
        @(negedge clk);
        clear_reqs();
        check(mem_en && !mem_we, "R9 read issued", {62'd0, mem_en, mem_we}, 64'd2);
        repeat (2) @(negedge clk);
        check(rd_valid && rd_data == exp_mem[8'h20], "R9 read after write", rd_data, exp_mem[8'h20]);

        // R10: reset during an in-flight read
        wait_slot(2'd0);
        put(3'd0, 1'b0, 8'h10, 64'd0);
        @(negedge clk);
        clear_reqs();
        rst = 1'b1;
        @(negedge clk);
        check(slot == 2'd0 && !rd_valid, "R10 reset restart", {62'd0, slot}, 64'd0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!rd_valid, "R10 read cancelled", {63'd0, rd_valid}, 64'd0);
        end

        report();
        $finish;
    end
endmodule